// File: doc/BRIEF.md
# Triggered Four-Level Address Walker

This block takes one transfer record and turns it into a stream of byte addresses. The record describes a loop nest of up to four levels. The innermost level steps through contiguous bytes. Each outer level adds its own signed stride when it advances. The record type sets how many levels are live. Any level above that depth behaves as if its count were one.

Two trigger slots can hold progress back. Each slot selects an input pulse as its source. Each slot also has a scope, which says how far the walker may go per pulse: one step of the second, third or fourth level, or the whole record. Pulses that arrive while earlier ones are still waiting to be served are counted, not dropped. An event pulse marks the beats chosen by the event-size code. A completion pulse on the final beat carries the record's command id.

One beat is emitted per cycle whenever the walker is allowed to run. No beat is emitted in any other cycle.

Top module: `tr4d_addr_gen`

## Requirements
- R1: After reset `rec_ready` is 1 and `beat_valid` is 0. A record is taken in the cycle where `rec_valid` and `rec_ready` are both 1. `rec_ready` stays 0 from the next cycle until the cycle after the record's final beat.
- R2: The flag word is decoded as follows: bits 3:0 type, bits 7:6 event size, bits 9:8 slot-0 source, bits 11:10 slot-0 scope, bits 13:12 slot-1 source, bits 15:14 slot-1 scope, bits 23:16 command id. Bits 4, 5 and 31:24 have no effect on any output.
- R3: Level indices i0..i3 count from 0, with i0 varying fastest. Beat addresses appear in this order, and each address is base + i0 + i1·s1 + i2·s2 + i3·s3 modulo 2^64, where s1..s3 are the sign-extended strides.
- R4: Type 0 uses level 0 only, type 1 uses levels 0..1, type 2 uses levels 0..2 and type 3 uses all four levels. The count of each unused level is taken as 1. Counts are never zero.
- R5: `beat_last` and `done_pulse` are 1 only on the final beat of a record. On that beat `done_cmd` equals the record's command id.
- R6: If both slot sources are 0, the record's beats appear on consecutive cycles with no gap.
- R7: Source code 1 selects `gtrig0`, 2 selects `gtrig1` and 3 selects `local_evt`. If any slot has a source other than 0, no beat appears until a selected input pulses. Pulses on inputs that no slot selects have no effect.
- R8: Each served pulse releases beats up to and including the beat that ends the scope. Scope 0 ends when level 0 wraps, scope 1 when levels 0..1 wrap, scope 2 when levels 0..2 wrap, and scope 3 at the end of the record. After that the walker waits for another pulse.
- R9: Pulses that arrive while earlier pulses are still being served are counted, up to 2^PEND_W−1 per slot. Each counted pulse later releases one scope.
- R10: `evt_pulse` follows the event-size code. Code 0 pulses on the final beat only. Code k (1..3) pulses on each beat where levels 0..k−1 all wrap. For a type with fewer than k+1 levels this reduces to the final beat only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Walker idle, record can be taken |
| rec_flags | input | 32 | Flag word |
| rec_base | input | ADDR_W | Base byte address |
| rec_icnt0 | input | CNT_W | Level-0 count (bytes) |
| rec_icnt1 | input | CNT_W | Level-1 count |
| rec_icnt2 | input | CNT_W | Level-2 count |
| rec_icnt3 | input | CNT_W | Level-3 count |
| rec_dim1 | input | STRIDE_W | Level-1 signed stride |
| rec_dim2 | input | STRIDE_W | Level-2 signed stride |
| rec_dim3 | input | STRIDE_W | Level-3 signed stride |
| gtrig0 | input | 1 | Global trigger pulse 0 |
| gtrig1 | input | 1 | Global trigger pulse 1 |
| local_evt | input | 1 | Local event pulse |
| beat_valid | output | 1 | Address beat present |
| beat_addr | output | ADDR_W | Beat byte address |
| beat_last | output | 1 | Final beat of the record |
| evt_pulse | output | 1 | Event selected by event size |
| done_pulse | output | 1 | Record complete |
| done_cmd | output | 8 | Command id of the completed record |

## Verification
The assertions assume every count in a record is at least one and the type field is in the range 0 to 3. They also assume that trigger inputs pulse only while a record is active. The stimulus keeps to these rules: every record uses counts of two or more, or the forced one, and trigger pulses are issued only after a record has been taken. The saturation assertion on the pending counters is reached only when at most a few pulses are waiting, so the bench never pushes a counter near its ceiling.

// File: rtl/tr4d_pkg.sv
package tr4d_pkg;
  localparam int NLVL = 4;

  localparam int F_TYPE_LO  = 0;
  localparam int F_ESIZE_LO = 6;
  localparam int F_S0SRC_LO = 8;
  localparam int F_S0SCP_LO = 10;
  localparam int F_S1SRC_LO = 12;
  localparam int F_S1SCP_LO = 14;
  localparam int F_CMD_LO   = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} walk_state_e;

  typedef struct packed {
    logic [1:0] src;
    logic [1:0] scope;
  } slot_cfg_t;
endpackage

// File: rtl/tr4d_trig_slot.sv
module tr4d_trig_slot #(
  parameter int PEND_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       count_en,
  input  logic [1:0] src,
  input  logic       gtrig0,
  input  logic       gtrig1,
  input  logic       local_evt,
  input  logic       take,
  output logic       pending
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              hit, inc;

  always_comb begin
    case (src)
      2'd1:    hit = gtrig0;
      2'd2:    hit = gtrig1;
      2'd3:    hit = local_evt;
      default: hit = 1'b0;
    endcase
    hit = hit & count_en;
  end

  assign inc = hit && ((cnt_q != PEND_MAX) || take);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + PEND_W'(inc) - PEND_W'(take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pending = (cnt_q != '0);

  assert_pulse_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !take && !clr && (cnt_q != PEND_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/tr4d_loop_walk.sv
module tr4d_loop_walk
  import tr4d_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 64,
  parameter int STRIDE_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic                             step,
  input  logic [ADDR_W-1:0]                base,
  input  logic [NLVL-1:0][CNT_W-1:0]       cnt,
  input  logic [NLVL-1:1][STRIDE_W-1:0]    dim,
  output logic [ADDR_W-1:0]                addr,
  output logic [NLVL-1:0]                  lvl_end
);
  localparam int EXT_W = ADDR_W - STRIDE_W;

  logic [NLVL-1:0][CNT_W-1:0]  idx_q, idx_d, lim_q;
  logic [NLVL-1:1][STRIDE_W-1:0] dim_q;
  logic [NLVL-1:1][ADDR_W-1:0] org_q, org_d;
  logic [NLVL-1:0]             at_max;
  int unsigned                 adv_lvl;
  logic                        carry;

  genvar g;
  generate
    for (g = 0; g < NLVL; g++) begin : g_end
      assign at_max[g] = (idx_q[g] == lim_q[g] - 1'b1);
      if (g == 0) begin : g_first
        assign lvl_end[g] = at_max[g];
      end else begin : g_chain
        assign lvl_end[g] = lvl_end[g-1] & at_max[g];
      end
    end
  endgenerate

  assign addr = org_q[1] + ADDR_W'(idx_q[0]);

  always_comb begin
    idx_d   = idx_q;
    org_d   = org_q;
    adv_lvl = 0;
    carry   = 1'b1;
    if (load) begin
      idx_d = '0;
      for (int j = 1; j < NLVL; j++) org_d[j] = base;
    end else if (step) begin
      for (int k = 0; k < NLVL; k++) begin
        if (carry) begin
          if (at_max[k]) begin
            idx_d[k] = '0;
          end else begin
            idx_d[k] = idx_q[k] + 1'b1;
            carry    = 1'b0;
            adv_lvl  = k;
          end
        end
      end
      if (!carry && adv_lvl >= 1) begin
        for (int j = 1; j < NLVL; j++) begin
          if (j <= adv_lvl)
            org_d[j] = org_q[adv_lvl] +
                       {{EXT_W{dim_q[adv_lvl][STRIDE_W-1]}}, dim_q[adv_lvl]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      org_q <= '0;
      lim_q <= '0;
      dim_q <= '0;
    end else begin
      if (load || step) begin
        idx_q <= idx_d;
        org_q <= org_d;
      end
      if (load) begin
        lim_q <= cnt;
        dim_q <= dim;
      end
    end
  end
endmodule

// File: rtl/tr4d_addr_gen.sv
module tr4d_addr_gen
  import tr4d_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 64,
  parameter int STRIDE_W = 32,
  parameter int PEND_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rec_valid,
  output logic                rec_ready,
  input  logic [31:0]         rec_flags,
  input  logic [ADDR_W-1:0]   rec_base,
  input  logic [CNT_W-1:0]    rec_icnt0,
  input  logic [CNT_W-1:0]    rec_icnt1,
  input  logic [CNT_W-1:0]    rec_icnt2,
  input  logic [CNT_W-1:0]    rec_icnt3,
  input  logic [STRIDE_W-1:0] rec_dim1,
  input  logic [STRIDE_W-1:0] rec_dim2,
  input  logic [STRIDE_W-1:0] rec_dim3,
  input  logic                gtrig0,
  input  logic                gtrig1,
  input  logic                local_evt,
  output logic                beat_valid,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic                beat_last,
  output logic                evt_pulse,
  output logic                done_pulse,
  output logic [7:0]          done_cmd
);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  walk_state_e state_q, state_d;
  slot_cfg_t   slot0_q, slot1_q, slot0_in, slot1_in;
  logic [1:0]  esize_q, scope_q, scope_d;
  logic [7:0]  cmd_q;
  logic        gated_q, gated_in;
  logic [1:0]  rtype;
  logic        load, step, take0, take1, pend0, pend1, scope_hit, evt_sel;
  logic [NLVL-1:0]              lvl_end;
  logic [NLVL-1:0][CNT_W-1:0]   eff_cnt;
  logic [NLVL-1:1][STRIDE_W-1:0] dims;

  assign rtype    = rec_flags[F_TYPE_LO +: 2];
  assign slot0_in = '{src: rec_flags[F_S0SRC_LO +: 2], scope: rec_flags[F_S0SCP_LO +: 2]};
  assign slot1_in = '{src: rec_flags[F_S1SRC_LO +: 2], scope: rec_flags[F_S1SCP_LO +: 2]};
  assign gated_in = (slot0_in.src != 2'd0) || (slot1_in.src != 2'd0);

  assign eff_cnt[0] = rec_icnt0;
  assign eff_cnt[1] = (rtype >= 2'd1) ? rec_icnt1 : ONE_CNT;
  assign eff_cnt[2] = (rtype >= 2'd2) ? rec_icnt2 : ONE_CNT;
  assign eff_cnt[3] = (rtype == 2'd3) ? rec_icnt3 : ONE_CNT;
  assign dims       = {rec_dim3, rec_dim2, rec_dim1};

  assign rec_ready = (state_q == ST_IDLE);
  assign load      = rec_ready && rec_valid;
  assign step      = (state_q == ST_RUN);
  assign take0     = (state_q == ST_WAIT) && pend0;
  assign take1     = (state_q == ST_WAIT) && !pend0 && pend1;
  assign scope_hit = lvl_end[scope_q];

  always_comb begin
    state_d = state_q;
    scope_d = scope_q;
    case (state_q)
      ST_IDLE: if (load) state_d = gated_in ? ST_WAIT : ST_RUN;
      ST_WAIT: begin
        if (take0) begin
          scope_d = slot0_q.scope;
          state_d = ST_RUN;
        end else if (take1) begin
          scope_d = slot1_q.scope;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (lvl_end[NLVL-1])          state_d = ST_IDLE;
        else if (gated_q && scope_hit) state_d = ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scope_q <= '0;
      slot0_q <= '0;
      slot1_q <= '0;
      esize_q <= '0;
      cmd_q   <= '0;
      gated_q <= 1'b0;
    end else begin
      state_q <= state_d;
      scope_q <= scope_d;
      if (load) begin
        slot0_q <= slot0_in;
        slot1_q <= slot1_in;
        esize_q <= rec_flags[F_ESIZE_LO +: 2];
        cmd_q   <= rec_flags[F_CMD_LO +: 8];
        gated_q <= gated_in;
      end
    end
  end

  tr4d_trig_slot #(.PEND_W(PEND_W)) u_slot0 (
    .clk(clk), .rst_n(rst_n), .clr(load), .count_en(state_q != ST_IDLE),
    .src(slot0_q.src), .gtrig0(gtrig0), .gtrig1(gtrig1), .local_evt(local_evt),
    .take(take0), .pending(pend0));

  tr4d_trig_slot #(.PEND_W(PEND_W)) u_slot1 (
    .clk(clk), .rst_n(rst_n), .clr(load), .count_en(state_q != ST_IDLE),
    .src(slot1_q.src), .gtrig0(gtrig0), .gtrig1(gtrig1), .local_evt(local_evt),
    .take(take1), .pending(pend1));

  tr4d_loop_walk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .base(rec_base),
    .cnt(eff_cnt), .dim(dims), .addr(beat_addr), .lvl_end(lvl_end));

  always_comb begin
    if (esize_q == 2'd0) evt_sel = lvl_end[NLVL-1];
    else                 evt_sel = lvl_end[esize_q - 2'd1];
  end

  assign beat_valid = step;
  assign beat_last  = step && lvl_end[NLVL-1];
  assign done_pulse = beat_last;
  assign evt_pulse  = step && evt_sel;
  assign done_cmd   = cmd_q;

  assert_accept_leaves_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_ready |=> !rec_ready);

  assert_inner_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !lvl_end[0] |=> beat_valid && (beat_addr == $past(beat_addr) + 1'b1));

  assert_free_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gated_q && beat_valid && !beat_last |=> beat_valid);

  assert_wait_after_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gated_q && beat_valid && scope_hit && !beat_last |=> !beat_valid);
endmodule

// File: tb/tr4d_addr_gen_bench.sv
`timescale 1ns/1ps
module tr4d_addr_gen_bench;
  logic        clk, rst_n, rec_valid, rec_ready;
  logic [31:0] rec_flags;
  logic [63:0] rec_base;
  logic [15:0] c0, c1, c2, c3;
  logic [31:0] d1, d2, d3;
  logic        gtrig0, gtrig1, local_evt;
  logic        beat_valid, beat_last, evt_pulse, done_pulse;
  logic [63:0] beat_addr;
  logic [7:0]  done_cmd;

  int nchk, nerr;
  int nb, ne, nd, nlast, cyc, first_cyc, last_cyc;
  logic [63:0] cap_addr [0:63];
  logic [7:0]  last_cmd;

  tr4d_addr_gen u_tr4d_addr_gen (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_flags(rec_flags), .rec_base(rec_base),
    .rec_icnt0(c0), .rec_icnt1(c1), .rec_icnt2(c2), .rec_icnt3(c3),
    .rec_dim1(d1), .rec_dim2(d2), .rec_dim3(d3),
    .gtrig0(gtrig0), .gtrig1(gtrig1), .local_evt(local_evt),
    .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_last(beat_last),
    .evt_pulse(evt_pulse), .done_pulse(done_pulse), .done_cmd(done_cmd));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (beat_valid) begin
      if (nb < 64) cap_addr[nb] = beat_addr;
      if (nb == 0) first_cyc = cyc;
      last_cyc = cyc;
      nb = nb + 1;
      if (beat_last) nlast = nlast + 1;
      if (evt_pulse) ne = ne + 1;
      if (done_pulse) begin
        nd = nd + 1;
        last_cmd = done_cmd;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    nb = 0; ne = 0; nd = 0; nlast = 0;
  endtask

  function automatic logic [31:0] mkflags(input int t, input int es, input int s0, input int p0,
                                          input int s1, input int p1, input int cmd);
    return {8'hA5, 8'(cmd), 2'(p1), 2'(s1), 2'(p0), 2'(s0), 2'(es), 2'b11, 4'(t)};
  endfunction

  task automatic send(input logic [31:0] f);
    @(negedge clk);
    while (!rec_ready) @(negedge clk);
    mon_clear();
    rec_flags = f; rec_valid = 1'b1;
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic pulse(input int which, input int len);
    @(negedge clk);
    if (which == 0) gtrig0 = 1'b1; else if (which == 1) gtrig1 = 1'b1; else local_evt = 1'b1;
    repeat (len) @(negedge clk);
    gtrig0 = 1'b0; gtrig1 = 1'b0; local_evt = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 400 && nd == 0; k++) @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0; cyc = 0;
    mon_clear();
    rst_n = 1'b0; rec_valid = 1'b0; rec_flags = '0; rec_base = '0;
    c0 = 0; c1 = 0; c2 = 0; c3 = 0; d1 = 0; d2 = 0; d3 = 0;
    gtrig0 = 0; gtrig1 = 0; local_evt = 0;
    repeat (3) @(negedge clk);
    check(rec_ready == 1'b1, "R1", "ready after reset", rec_ready, 1);
    check(beat_valid == 1'b0, "R1", "no beat after reset", beat_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Ungated sweep over all types and event sizes (R2 R3 R4 R5 R6 R10)
    c0 = 3; c1 = 2; c2 = 2; c3 = 2;
    d1 = 32'h40; d2 = 32'hFFFF_FF00; d3 = 32'h1000;
    rec_base = 64'h0000_1234_0000_0010;
    for (int t = 0; t < 4; t++) begin
      for (int es = 0; es < 4; es++) begin
        int e1, e2, e3, tot, bad, expev, cmd;
        logic [63:0] ea;
        e1 = (t >= 1) ? 2 : 1; e2 = (t >= 2) ? 2 : 1; e3 = (t == 3) ? 2 : 1;
        tot = 3 * e1 * e2 * e3;
        cmd = 8'h40 + t * 4 + es;
        send(mkflags(t, es, 0, 0, 0, 0, cmd));
        wait_done();
        @(negedge clk);
        check(nb == tot, "R4", "beat count", nb, tot);
        bad = 0;
        for (int i3 = 0; i3 < e3; i3++)
          for (int i2 = 0; i2 < e2; i2++)
            for (int i1 = 0; i1 < e1; i1++)
              for (int i0 = 0; i0 < 3; i0++) begin
                int n;
                n = ((i3 * e2 + i2) * e1 + i1) * 3 + i0;
                ea = rec_base + 64'(i0) + 64'(i1) * 64'h40 - 64'(i2) * 64'h100 + 64'(i3) * 64'h1000;
                if (n < nb && cap_addr[n] !== ea) bad++;
              end
        check(bad == 0, "R3", "address order mismatches", bad, 0);
        check(nlast == 1 && nd == 1, "R5", "single last/done", nlast * 16 + nd, 17);
        check(last_cmd == 8'(cmd), "R2", "command id echo", last_cmd, cmd);
        check(last_cyc - first_cyc + 1 == nb, "R6", "no gaps", last_cyc - first_cyc + 1, nb);
        case (es)
          0: expev = 1;
          1: expev = e1 * e2 * e3;
          2: expev = e2 * e3;
          default: expev = e3;
        endcase
        check(ne == expev, "R10", "event count", ne, expev);
      end
    end
    check(rec_ready == 1'b1, "R1", "ready after record", rec_ready, 1);

    // Gated: type 2, slot0 on gtrig0 scope 0 (one level-0 wrap per pulse)
    c0 = 2; c1 = 3; c2 = 2; c3 = 5;
    send(mkflags(2, 0, 1, 0, 0, 0, 8'h11));
    repeat (8) @(negedge clk);
    check(nb == 0, "R7", "held before trigger", nb, 0);
    check(rec_ready == 1'b0, "R1", "busy while held", rec_ready, 0);
    pulse(1, 1); pulse(2, 1);
    repeat (8) @(negedge clk);
    check(nb == 0, "R7", "unselected inputs ignored", nb, 0);
    pulse(0, 1);
    repeat (10) @(negedge clk);
    check(nb == 2, "R8", "one row per pulse", nb, 2);
    pulse(0, 2);
    repeat (15) @(negedge clk);
    check(nb == 6, "R9", "two queued pulses served", nb, 6);
    pulse(0, 3);
    wait_done();
    @(negedge clk);
    check(nb == 12 && nd == 1, "R4", "type2 ignores count3", nb, 12);
    check(last_cmd == 8'h11, "R5", "done cmd gated", last_cmd, 8'h11);

    // Gated: type 3, slot0 none, slot1 on local event scope 1, event size 2
    c0 = 2; c1 = 2; c2 = 2; c3 = 2;
    send(mkflags(3, 2, 0, 3, 3, 1, 8'h22));
    pulse(0, 1);
    repeat (8) @(negedge clk);
    check(nb == 0, "R7", "none-source slot does not release", nb, 0);
    pulse(2, 1);
    repeat (12) @(negedge clk);
    check(nb == 4, "R8", "scope 1 releases level-1 wrap", nb, 4);
    pulse(2, 1);
    repeat (12) @(negedge clk);
    check(nb == 8, "R8", "second scope-1 release", nb, 8);
    pulse(2, 2);
    wait_done();
    @(negedge clk);
    check(nb == 16, "R8", "all beats after pulses", nb, 16);
    check(ne == 4, "R10", "gated event count es2", ne, 4);

    // Gated: type 1, slot0 on gtrig1 scope 3 (whole record)
    c0 = 2; c1 = 3;
    send(mkflags(1, 1, 2, 3, 0, 0, 8'h33));
    repeat (6) @(negedge clk);
    check(nb == 0, "R7", "held on gtrig1", nb, 0);
    pulse(1, 1);
    repeat (15) @(negedge clk);
    check(nb == 6 && nd == 1, "R8", "scope 3 runs whole record", nb, 6);
    check(ne == 3, "R10", "event per level-0 wrap", ne, 3);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule